// File: doc/BRIEF.md
# Page Write and Programming Sequencer

This block sits behind a serial memory front end and handles the data phase of a memory write frame. Once the front end has decoded a write command and its start address, the block shifts the incoming data bits into bytes. It places each byte into a page-sized holding buffer at the next offset inside the addressed page, wrapping to offset zero when the end of the page is reached. A later byte sent to an offset already filled replaces the earlier one.

When chip select is released, the block checks how the frame ended. If at least one whole byte was received and no partial byte is pending, it starts a self-timed programming cycle. The cycle length is a programmable count of system clocks. During the cycle the block commits every received byte that lies outside the write-protected range to the array write port. Offsets that never received a byte are not written. While the cycle runs the block reports busy and rejects every command other than the status read, which returns all ones. When the cycle ends it asks for write-enable to be cleared.

All inputs are single-cycle strobes or levels in the system clock domain. The front end is expected to have already synchronised the serial clock and chip select into this domain.

Top module: `page_prog_seq`

## Requirements
- R1: After reset `busy`, `mem_we`, `wen_clear` and `op_reject` are all low.
- R2: Data bytes arrive MSB first on `bit_val`, one bit per `bit_tick`. They fill consecutive page offsets starting at the offset held in the low log2(PAGE_BYTES) bits of `wr_addr`. Each filled offset is committed once, in ascending offset order, to address {page bits of `wr_addr`, offset} with its byte.
- R3: When more than PAGE_BYTES bytes are sent, the offset wraps from PAGE_BYTES-1 to 0 and the last byte sent to an offset is the one committed.
- R4: A `cs_rise` that comes while a partial byte (1 to 7 bits) is pending does not start programming, and nothing is written.
- R5: A `cs_rise` on a frame that holds no complete data byte does not start programming.
- R6: A valid `cs_rise` raises `busy` in the next cycle. `busy` then stays high for exactly PROG_CYCLES cycles, and all commits fall inside that window.
- R7: `wen_clear` pulses for one cycle, in the cycle where `busy` falls, and only after a programming cycle.
- R8: Block protect `bp` is latched at the valid `cs_rise`. Code 0 protects nothing. Code 1 protects addresses whose two top bits are 11. Code 2 protects addresses whose top bit is 1. Code 3 protects every address. Protected bytes are never written, but the cycle still runs.
- R9: While `busy` is high, `op_valid` with `op_is_rdsr` low gives `op_reject` high, and `rdsr_data` reads 0xFF. When idle, `op_reject` stays low and `rdsr_data` equals `status_in`.
- R10: `wr_start` is ignored when `wen` is low or while `busy` is high. The frame that follows commits nothing and no cycle starts.
- R11: Page offsets that received no byte in the frame are not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Write command and address decoded (pulse) |
| wr_addr | input | ADDR_W | Start address of the write frame |
| bit_tick | input | 1 | One data bit sampled (pulse) |
| bit_val | input | 1 | Value of the sampled data bit |
| cs_rise | input | 1 | Chip select released (pulse) |
| wen | input | 1 | Current write-enable state |
| bp | input | 2 | Block protect code |
| op_valid | input | 1 | An opcode has been decoded (pulse) |
| op_is_rdsr | input | 1 | The decoded opcode is a status read |
| status_in | input | 8 | Live status byte from the register file |
| busy | output | 1 | Programming cycle in progress |
| op_reject | output | 1 | Decoded opcode refused because of busy |
| rdsr_data | output | 8 | Status byte to shift out |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |
| wen_clear | output | 1 | Request to clear write-enable (pulse) |

## Verification
`busy` rises one cycle after the valid `cs_rise` is sampled. The commit for page offset k appears on `mem_we` k+1 cycles after `busy` rises. `wen_clear` coincides with the first cycle in which `busy` is low, PROG_CYCLES cycles after it rose. `op_reject` and `rdsr_data` are combinational and settle in the same cycle as `op_valid`. The bench drives all inputs on falling edges and samples on falling edges, so every registered result is read one full edge after it is produced. A monitor pops each commit from an expected queue the moment it appears. It also counts busy cycles and clear pulses, and the totals are checked once each frame has drained.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_COLLECT = 2'd1,
        SEQ_PROG    = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } byte_evt_t;

    localparam logic [7:0] BUSY_STATUS = 8'hFF;

    // top2 = two most significant address bits, code = block protect code
    function automatic logic prot_hit(input logic [1:0] top2, input logic [1:0] code);
        case (code)
            2'd0:    prot_hit = 1'b0;
            2'd1:    prot_hit = (top2 == 2'b11);
            2'd2:    prot_hit = top2[1];
            default: prot_hit = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pw_byte_shifter.sv
module pw_byte_shifter
    import pw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      bit_tick,
    input  logic      bit_val,
    output byte_evt_t evt,
    output logic      partial
);
    logic [2:0] cnt;
    logic [6:0] sh;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
            sh  <= '0;
        end else if (bit_tick) begin
            cnt <= cnt + 3'd1;
            sh  <= {sh[5:0], bit_val};
        end
    end

    always_comb begin
        evt.valid = bit_tick && (cnt == 3'd7);
        evt.data  = {sh, bit_val};
        partial   = (cnt != 3'd0);
    end
endmodule

// File: rtl/pw_page_buffer.sv
module pw_page_buffer #(
    parameter int PAGE_BYTES = 32,
    parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [OFF_W-1:0] start_off,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic [OFF_W-1:0] rd_slot,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             any_valid
);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

    logic [7:0]            store [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] filled;
    logic [OFF_W-1:0]      ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            filled <= '0;
            ptr    <= '0;
        end else if (clear) begin
            filled <= '0;
            ptr    <= start_off;
        end else if (wr_en) begin
            filled[ptr] <= 1'b1;
            ptr         <= (ptr == LAST_OFF) ? '0 : ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clear) begin
            store[ptr] <= wr_data;
        end
    end

    always_comb begin
        rd_data   = store[rd_slot];
        rd_valid  = filled[rd_slot];
        any_valid = |filled;
    end
endmodule

// File: rtl/pw_prog_timer.sv
module pw_prog_timer #(
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 5000,
    parameter int OFF_W       = $clog2(PAGE_BYTES),
    parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             active,
    output logic [OFF_W-1:0] slot,
    output logic             slot_live,
    output logic             done
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PROG_CYCLES - 1);
    localparam logic [CNT_W-1:0] PAGE_CNT = CNT_W'(PAGE_BYTES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST_CNT) begin
                active <= 1'b0;
            end
            cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        done      = active && (cnt == LAST_CNT);
        slot_live = active && (cnt < PAGE_CNT);
        slot      = cnt[OFF_W-1:0];
    end
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
    import pw_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int PAGE_BYTES  = 32,
    parameter int PROG_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              bit_tick,
    input  logic              bit_val,
    input  logic              cs_rise,
    input  logic              wen,
    input  logic [1:0]        bp,
    input  logic              op_valid,
    input  logic              op_is_rdsr,
    input  logic [7:0]        status_in,
    output logic              busy,
    output logic              op_reject,
    output logic [7:0]        rdsr_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              wen_clear
);
    localparam int OFF_W  = $clog2(PAGE_BYTES);
    localparam int BASE_W = ADDR_W - OFF_W;
    localparam int CNT_W  = $clog2(PROG_CYCLES + 1);

    seq_state_t        state;
    logic [BASE_W-1:0] page_base;
    logic [1:0]        bp_lat;

    byte_evt_t        evt;
    logic             partial;
    logic             start_ok;
    logic             prog_go;
    logic             shift_tick;
    logic [7:0]       buf_data;
    logic             buf_valid;
    logic             buf_any;
    logic             tmr_active;
    logic [OFF_W-1:0] tmr_slot;
    logic             tmr_live;
    logic             tmr_done;
    logic [ADDR_W-1:0] commit_addr;

    always_comb begin
        start_ok    = wr_start && wen && (state == SEQ_IDLE);
        shift_tick  = bit_tick && (state == SEQ_COLLECT);
        prog_go     = (state == SEQ_COLLECT) && cs_rise && buf_any && !partial;
        busy        = (state == SEQ_PROG);
        op_reject   = busy && op_valid && !op_is_rdsr;
        rdsr_data   = busy ? BUSY_STATUS : status_in;
        commit_addr = {page_base, tmr_slot};
    end

    pw_byte_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .clear    (start_ok),
        .bit_tick (shift_tick),
        .bit_val  (bit_val),
        .evt      (evt),
        .partial  (partial)
    );

    pw_page_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .OFF_W      (OFF_W)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .clear     (start_ok),
        .start_off (wr_addr[OFF_W-1:0]),
        .wr_en     (evt.valid),
        .wr_data   (evt.data),
        .rd_slot   (tmr_slot),
        .rd_data   (buf_data),
        .rd_valid  (buf_valid),
        .any_valid (buf_any)
    );

    pw_prog_timer #(
        .PAGE_BYTES  (PAGE_BYTES),
        .PROG_CYCLES (PROG_CYCLES),
        .OFF_W       (OFF_W),
        .CNT_W       (CNT_W)
    ) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .start     (prog_go),
        .active    (tmr_active),
        .slot      (tmr_slot),
        .slot_live (tmr_live),
        .done      (tmr_done)
    );

    // sequencer state
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            page_base <= '0;
            bp_lat    <= '0;
            wen_clear <= 1'b0;
        end else begin
            wen_clear <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start_ok) begin
                        state     <= SEQ_COLLECT;
                        page_base <= wr_addr[ADDR_W-1:OFF_W];
                    end
                end
                SEQ_COLLECT: begin
                    if (prog_go) begin
                        state  <= SEQ_PROG;
                        bp_lat <= bp;
                    end else if (cs_rise) begin
                        state <= SEQ_IDLE;
                    end
                end
                SEQ_PROG: begin
                    if (tmr_done) begin
                        state     <= SEQ_IDLE;
                        wen_clear <= 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // commit port, one page offset per cycle at the start of the cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we    <= tmr_live && buf_valid &&
                         !prot_hit(commit_addr[ADDR_W-1 -: 2], bp_lat);
            mem_addr  <= commit_addr;
            mem_wdata <= buf_data;
        end
    end

    // commits only inside the busy window
    assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // busy only begins on a chip select release
    assert_start_on_cs_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cs_rise));

    // no commit lands in the protected range
    assert_no_prot_commit_R8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !prot_hit(mem_addr[ADDR_W-1 -: 2], bp_lat));

    // clear request accompanies the end of busy
    assert_clear_at_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> wen_clear);

    // clear request lasts a single cycle
    assert_clear_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        wen_clear |=> !wen_clear);

    // timer and sequencer agree on the cycle window
    assert_timer_match_R6: assert property (@(posedge clk) disable iff (rst)
        tmr_active |-> busy);
endmodule

// File: tb/page_prog_seq_bench.sv
module page_prog_seq_bench;
    localparam int ADDR_W = 13;
    localparam int PAGE   = 32;
    localparam int PROG   = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_start = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic              bit_tick = 1'b0;
    logic              bit_val = 1'b0;
    logic              cs_rise = 1'b0;
    logic              wen = 1'b0;
    logic [1:0]        bp = 2'd0;
    logic              op_valid = 1'b0;
    logic              op_is_rdsr = 1'b0;
    logic [7:0]        status_in = 8'h4A;
    logic              busy, op_reject, mem_we, wen_clear;
    logic [7:0]        rdsr_data, mem_wdata;
    logic [ADDR_W-1:0] mem_addr;

    int checks = 0;
    int failures = 0;
    int busy_total = 0;
    int clr_total = 0;
    logic [ADDR_W+7:0] expq [$];

    always #10 clk = ~clk;

    page_prog_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE), .PROG_CYCLES(PROG)) u_page_prog_seq (
        .clk(clk), .rst(rst), .wr_start(wr_start), .wr_addr(wr_addr),
        .bit_tick(bit_tick), .bit_val(bit_val), .cs_rise(cs_rise), .wen(wen),
        .bp(bp), .op_valid(op_valid), .op_is_rdsr(op_is_rdsr), .status_in(status_in),
        .busy(busy), .op_reject(op_reject), .rdsr_data(rdsr_data),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wen_clear(wen_clear)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: scoreboard for commits, counters for busy and clear
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_total++;
            if (wen_clear) clr_total++;
            if (mem_we) begin
                if (expq.size() == 0) begin
                    check("R11 unexpected commit", {11'd0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
                end else begin
                    logic [ADDR_W+7:0] e;
                    e = expq.pop_front();
                    check("R2 commit addr/data", {11'd0, mem_addr, mem_wdata}, {11'd0, e});
                end
            end
        end
    end

    function automatic logic bench_prot(input logic [ADDR_W-1:0] a, input logic [1:0] c);
        return (c == 2'd3) || (c == 2'd2 && a[12]) || (c == 2'd1 && a[12] && a[11]);
    endfunction

    task automatic pulse_start(input logic [ADDR_W-1:0] a);
        @(negedge clk); wr_start = 1'b1; wr_addr = a;
        @(negedge clk); wr_start = 1'b0;
    endtask

    task automatic send_bits(input logic [7:0] v, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1; bit_val = v[7-i];
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic pulse_cs();
        @(negedge clk); cs_rise = 1'b1;
        @(negedge clk); cs_rise = 1'b0;
    endtask

    task automatic run_frame(input string req, input logic [ADDR_W-1:0] a, input int nb,
                             input int extra, input logic [1:0] code, input logic we,
                             input logic [7:0] seed);
        logic [7:0] sd [PAGE];
        logic       sv [PAGE];
        logic       good;
        int b0, c0;
        for (int s = 0; s < PAGE; s++) begin sv[s] = 1'b0; sd[s] = 8'h00; end
        for (int i = 0; i < nb; i++) begin
            int s;
            s = (int'(a[4:0]) + i) % PAGE;
            sv[s] = 1'b1;
            sd[s] = seed + 8'(i * 7);
        end
        good = we && (nb > 0) && (extra == 0);
        if (good) begin
            for (int s = 0; s < PAGE; s++) begin
                logic [ADDR_W-1:0] ca;
                ca = {a[ADDR_W-1:5], 5'(s)};
                if (sv[s] && !bench_prot(ca, code)) expq.push_back({ca, sd[s]});
            end
        end
        @(negedge clk); bp = code; wen = we;
        b0 = busy_total; c0 = clr_total;
        pulse_start(a);
        for (int i = 0; i < nb; i++) send_bits(seed + 8'(i * 7), 8);
        if (extra > 0) send_bits(8'hA5, extra);
        pulse_cs();
        repeat (PROG + 8) @(negedge clk);
        check({req, " busy cycles"}, busy_total - b0, good ? PROG : 0);
        check({req, " R7 clear pulses"}, clr_total - c0, good ? 1 : 0);
        check({req, " pending commits"}, expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int b0, c0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 mem_we", mem_we, 0);
        check("R1 wen_clear", wen_clear, 0);
        check("R1 op_reject", op_reject, 0);
        @(negedge clk); rst = 1'b0;
        repeat (2) @(negedge clk);

        run_frame("R2/R11 three bytes", 13'h0105, 3, 0, 2'd0, 1'b1, 8'h31);
        run_frame("R3 wrap 35 bytes", 13'h03FE, 35, 0, 2'd0, 1'b1, 8'h10);
        run_frame("R2 full page", 13'h0460, 32, 0, 2'd0, 1'b1, 8'hC3);
        run_frame("R4 partial byte", 13'h0040, 2, 3, 2'd0, 1'b1, 8'h55);
        run_frame("R5 no data byte", 13'h0080, 0, 0, 2'd0, 1'b1, 8'h00);
        run_frame("R5 bits only", 13'h0080, 0, 5, 2'd0, 1'b1, 8'h00);
        run_frame("R10 wen low", 13'h00A0, 4, 0, 2'd0, 1'b0, 8'h77);
        run_frame("R8 code1 top quarter", 13'h1820, 4, 0, 2'd1, 1'b1, 8'h21);
        run_frame("R8 code1 below quarter", 13'h1020, 4, 0, 2'd1, 1'b1, 8'h41);
        run_frame("R8 code2 lower half", 13'h0F10, 3, 0, 2'd2, 1'b1, 8'h61);
        run_frame("R8 code2 upper half", 13'h1F10, 3, 0, 2'd2, 1'b1, 8'h81);
        run_frame("R8 code3 all", 13'h0000, 2, 0, 2'd3, 1'b1, 8'h91);

        // R6 / R9 / R10 during a programming cycle
        expq.push_back({13'h0200, 8'hE1});
        expq.push_back({13'h0201, 8'hE8});
        @(negedge clk); bp = 2'd0; wen = 1'b1;
        b0 = busy_total; c0 = clr_total;
        pulse_start(13'h0200);
        send_bits(8'hE1, 8);
        send_bits(8'hE8, 8);
        pulse_cs();
        check("R6 busy one cycle after cs_rise", busy, 1);
        repeat (3) @(negedge clk);
        op_valid = 1'b1; op_is_rdsr = 1'b0;
        #2 check("R9 reject while busy", op_reject, 1);
        op_is_rdsr = 1'b1;
        #2 check("R9 status read allowed", op_reject, 0);
        check("R9 busy status value", rdsr_data, 8'hFF);
        @(negedge clk); op_valid = 1'b0; op_is_rdsr = 1'b0;
        pulse_start(13'h0300);
        send_bits(8'h3C, 8);
        pulse_cs();
        repeat (PROG + 8) @(negedge clk);
        check("R10 busy cycles with frame during busy", busy_total - b0, PROG);
        check("R7 single clear pulse", clr_total - c0, 1);
        check("R10 no extra commits", expq.size(), 0);
        op_valid = 1'b1;
        #2 check("R9 idle no reject", op_reject, 0);
        check("R9 idle status passes", rdsr_data, 8'h4A);
        @(negedge clk); op_valid = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule